// File: doc/BRIEF.md
# Register Writer Mapping Table

This block records, for every architectural register, which in-flight write last defined it. A write is named by a small tag. Registers are arranged in fixed groups. Each group holds one full-width register and a chain of nested sub-registers inside it, so a register's super-registers are the wider members of its group and its sub-registers are the narrower ones. A dispatch stage uses the block in four ways. It records new writes, and it drops a write's mappings when that write retires. It asks which writers a source operand depends on. It also asks whether a group of new writes fits within the mapping budget.

Adding a mapping spreads the tag down to every narrower alias. The tag reaches the wider aliases only when the write fully updates them. Retirement clears only those alias entries that still carry the retiring tag, so a later writer's ownership is never lost. The block counts the mappings currently in use, the peak of that count and the total created. A budget limits the mappings in use, and an oversized request raises that budget.

Top module: `reg_writer_map`

## Requirements
- R1: Register ID is 1 + 3*group + level, where level 0 is the full register and levels 1 and 2 are its nested sub-registers (a higher level is narrower). A legal add writes the tag into the target register's entry and into the entries of every narrower register of the same group. The result is visible on the next cycle.
- R2: When add_full is 1, a legal add also writes the tag into the entries of the wider registers of the same group. When add_full is 0, those entries are left unchanged.
- R3: An invalidate whose target entry is empty changes nothing. Otherwise it lowers used_cnt by one, except that used_cnt never goes below 0.
- R4: An invalidate clears the entries of the target and its narrower registers only where they hold inv_tag. When inv_full is 1, the wider registers of the group are treated the same way. When inv_full is 0, the wider registers are left untouched.
- R5: lk_mask is combinational. Bit t is set when tag t is held by the entry of lk_reg or by any of its narrower registers. A tag held by several of these entries shows as one bit. An illegal lk_reg gives 0.
- R6: q_ok is combinational. It is 1 when q_num + used_cnt <= budget_cur. A budget of 0 (parameter BUDGET=0) means unlimited, and q_ok is then always 1.
- R7: When q_num > budget_cur and the budget is nonzero, q_ok compares against q_num instead. With q_valid high, budget_cur becomes q_num on the next cycle. A nonzero budget never decreases.
- R8: Each legal add raises used_cnt and created_cnt by one. It also raises peak_cnt by one if peak_cnt equaled used_cnt before the add. peak_cnt is never below used_cnt.
- R9: Register ID 0 and IDs of 13 or more are illegal. A request on either port that names one is ignored, and id_err is 1 in that same cycle.
- R10: When add_valid is 1, the invalidate request of the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_valid | input | 1 | Add-mapping request |
| add_reg | input | 4 | Register written |
| add_tag | input | 3 | Writer tag |
| add_full | input | 1 | Write fully updates wider registers |
| inv_valid | input | 1 | Invalidate request |
| inv_reg | input | 4 | Register of the retiring write |
| inv_tag | input | 3 | Retiring writer tag |
| inv_full | input | 1 | Retiring write fully updated wider registers |
| lk_reg | input | 4 | Register read by a lookup |
| lk_mask | output | 8 | One bit per writer tag the read depends on |
| q_valid | input | 1 | Availability query strobe |
| q_num | input | 8 | Number of new writes asked for |
| q_ok | output | 1 | Writes fit within the budget |
| used_cnt | output | 8 | Mappings in use |
| peak_cnt | output | 8 | Peak of used_cnt |
| created_cnt | output | 16 | Mappings created since reset |
| budget_cur | output | 8 | Current mapping budget |
| id_err | output | 1 | An illegal register ID was named this cycle |

## Verification
Directed sequences first build overlapping mappings. A narrow write lands inside an older full-register write. A full-update write lands in an empty group. These cases separate downward spreading from upward spreading and show the mask merging distinct tags. Invalidates are then issued with a mismatched tag, with a cleared flag, and against an empty entry. These show that only entries still owned by the retiring writer are cleared, and that the used count moves only when the target entry was occupied. Collisions between add and invalidate, illegal IDs, queries at and just past the budget, and an oversized query follow. A long seeded random mix of all ports is then compared against a bench model on every cycle.

// File: rtl/reg_writer_map.sv
module reg_writer_map #(
  parameter int NUM_FULL = 4,
  parameter int LEVELS   = 3,
  parameter int TAG_W    = 3,
  parameter int CNT_W    = 8,
  parameter int CRE_W    = 16,
  parameter int BUDGET   = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         add_valid,
  input  logic [$clog2(1+NUM_FULL*LEVELS)-1:0] add_reg,
  input  logic [TAG_W-1:0]             add_tag,
  input  logic                         add_full,
  input  logic                         inv_valid,
  input  logic [$clog2(1+NUM_FULL*LEVELS)-1:0] inv_reg,
  input  logic [TAG_W-1:0]             inv_tag,
  input  logic                         inv_full,
  input  logic [$clog2(1+NUM_FULL*LEVELS)-1:0] lk_reg,
  output logic [(1<<TAG_W)-1:0]        lk_mask,
  input  logic                         q_valid,
  input  logic [CNT_W-1:0]             q_num,
  output logic                         q_ok,
  output logic [CNT_W-1:0]             used_cnt,
  output logic [CNT_W-1:0]             peak_cnt,
  output logic [CRE_W-1:0]             created_cnt,
  output logic [CNT_W-1:0]             budget_cur,
  output logic                         id_err
);
  localparam int NREG  = 1 + NUM_FULL * LEVELS;
  localparam int ID_W  = $clog2(NREG);
  localparam int NSLOT = 1 << ID_W;

  logic             ent_v [NSLOT];
  logic [TAG_W-1:0] ent_t [NSLOT];

  function automatic logic legal(int r);
    return r >= 1 && r < NREG;
  endfunction

  function automatic logic narrower(int t, int i);
    return legal(t) && legal(i) && (t-1)/LEVELS == (i-1)/LEVELS && (i-1)%LEVELS > (t-1)%LEVELS;
  endfunction

  function automatic logic wider(int t, int i);
    return legal(t) && legal(i) && (t-1)/LEVELS == (i-1)/LEVELS && (i-1)%LEVELS < (t-1)%LEVELS;
  endfunction

  logic add_ok, inv_ok;
  assign add_ok = add_valid && legal(int'(add_reg));
  assign inv_ok = inv_valid && !add_valid && legal(int'(inv_reg)) && ent_v[inv_reg];
  assign id_err = (add_valid && !legal(int'(add_reg))) || (inv_valid && !legal(int'(inv_reg)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        ent_v[i] <= 1'b0;
        ent_t[i] <= '0;
      end
      used_cnt    <= '0;
      peak_cnt    <= '0;
      created_cnt <= '0;
      budget_cur  <= CNT_W'(BUDGET);
    end else begin
      if (add_ok) begin
        for (int i = 0; i < NSLOT; i++)
          if (i == int'(add_reg) || narrower(int'(add_reg), i) || (add_full && wider(int'(add_reg), i))) begin
            ent_v[i] <= 1'b1;
            ent_t[i] <= add_tag;
          end
        used_cnt    <= used_cnt + 1'b1;
        created_cnt <= created_cnt + 1'b1;
        if (peak_cnt == used_cnt) peak_cnt <= peak_cnt + 1'b1;
      end else if (inv_ok) begin
        for (int i = 0; i < NSLOT; i++)
          if ((i == int'(inv_reg) || narrower(int'(inv_reg), i) || (inv_full && wider(int'(inv_reg), i)))
              && ent_v[i] && ent_t[i] == inv_tag)
            ent_v[i] <= 1'b0;
        if (used_cnt != '0) used_cnt <= used_cnt - 1'b1;
      end
      if (q_valid && budget_cur != '0 && q_num > budget_cur) budget_cur <= q_num;
    end
  end

  always_comb begin
    lk_mask = '0;
    for (int i = 0; i < NSLOT; i++)
      if ((i == int'(lk_reg) && legal(i)) || narrower(int'(lk_reg), i))
        if (ent_v[i]) lk_mask[ent_t[i]] = 1'b1;
  end

  logic [CNT_W-1:0] eff;
  assign eff  = (q_num > budget_cur) ? q_num : budget_cur;
  assign q_ok = (budget_cur == '0) || ({1'b0, q_num} + {1'b0, used_cnt} <= {1'b0, eff});

  a_r8_peak_ge_used: assert property (@(posedge clk) disable iff (!rst_n) peak_cnt >= used_cnt);
  a_r8_add_counts: assert property (@(posedge clk) disable iff (!rst_n)
    add_ok |=> used_cnt == $past(used_cnt) + 1'b1 && created_cnt == $past(created_cnt) + 1'b1);
  a_r9_err_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (id_err && !add_ok && !inv_ok) |=> $stable(used_cnt) && $stable(created_cnt));
  a_r10_add_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (add_ok && inv_valid) |=> used_cnt == $past(used_cnt) + 1'b1);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (used_cnt == '0 && !add_valid) |=> used_cnt == '0);
  a_r7_budget_mono: assert property (@(posedge clk) disable iff (!rst_n)
    budget_cur != '0 |=> budget_cur >= $past(budget_cur));
endmodule

// File: tb/test_reg_writer_map.sv
`timescale 1ns/1ps
module test_reg_writer_map;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic add_valid, add_full, inv_valid, inv_full, q_valid;
  logic [3:0] add_reg, inv_reg, lk_reg;
  logic [2:0] add_tag, inv_tag;
  logic [7:0] q_num, lk_mask, used_cnt, peak_cnt, budget_cur;
  logic [15:0] created_cnt;
  logic q_ok, id_err;

  logic [7:0] u_mask, u_used, u_peak, u_budget;
  logic [15:0] u_created;
  logic u_ok, u_err;

  reg_writer_map i_reg_writer_map (.clk, .rst_n, .add_valid, .add_reg, .add_tag, .add_full,
    .inv_valid, .inv_reg, .inv_tag, .inv_full, .lk_reg, .lk_mask, .q_valid, .q_num, .q_ok,
    .used_cnt, .peak_cnt, .created_cnt, .budget_cur, .id_err);

  reg_writer_map #(.BUDGET(0)) i_reg_writer_map_unl (.clk, .rst_n, .add_valid(1'b0), .add_reg(4'd0),
    .add_tag(3'd0), .add_full(1'b0), .inv_valid(1'b0), .inv_reg(4'd0), .inv_tag(3'd0), .inv_full(1'b0),
    .lk_reg(4'd0), .lk_mask(u_mask), .q_valid, .q_num, .q_ok(u_ok), .used_cnt(u_used),
    .peak_cnt(u_peak), .created_cnt(u_created), .budget_cur(u_budget), .id_err(u_err));

  int checks = 0, errors = 0;
  bit mv [16];
  int mt [16];
  int used = 0, peak = 0, created = 0, budget = 8;

  function automatic bit legal(int r); return r >= 1 && r < 13; endfunction
  function automatic bit f_sub(int t, int i);
    return legal(t) && legal(i) && (t-1)/3 == (i-1)/3 && (i-1)%3 > (t-1)%3;
  endfunction
  function automatic bit f_sup(int t, int i);
    return legal(t) && legal(i) && (t-1)/3 == (i-1)/3 && (i-1)%3 < (t-1)%3;
  endfunction
  function automatic int f_mask(int r);
    int m = 0;
    for (int i = 1; i < 13; i++)
      if ((i == r || f_sub(r, i)) && mv[i]) m |= (1 << mt[i]);
    return legal(r) ? m : 0;
  endfunction
  function automatic bit f_ok(int n);
    int eff = (n > budget) ? n : budget;
    if (budget == 0) return 1;
    return n + used <= eff;
  endfunction

  task automatic chk(string tg, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
    end
  endtask

  task automatic step(string tg, bit av, int ar, int at, bit af, bit iv, int ir, int it, bit ifl,
                      int lk, bit qv, int qn);
    bit aok, iok;
    add_valid = av; add_reg = ar[3:0]; add_tag = at[2:0]; add_full = af;
    inv_valid = iv; inv_reg = ir[3:0]; inv_tag = it[2:0]; inv_full = ifl;
    lk_reg = lk[3:0]; q_valid = qv; q_num = qn[7:0];
    #1;
    chk({tg, " R5 lk_mask"}, int'(lk_mask), f_mask(lk));
    chk({tg, " R6 q_ok"}, int'(q_ok), int'(f_ok(qn)));
    chk({tg, " R9 id_err"}, int'(id_err), int'((av && !legal(ar)) || (iv && !legal(ir))));
    aok = av && legal(ar);
    iok = iv && !av && legal(ir) && mv[ir];
    if (aok) begin
      for (int i = 1; i < 13; i++)
        if (i == ar || f_sub(ar, i) || (af && f_sup(ar, i))) begin mv[i] = 1; mt[i] = at; end
      if (peak == used) peak++;
      used++; created++;
    end else if (iok) begin
      for (int i = 1; i < 13; i++)
        if ((i == ir || f_sub(ir, i) || (ifl && f_sup(ir, i))) && mv[i] && mt[i] == it) mv[i] = 0;
      if (used > 0) used--;
    end
    if (qv && budget != 0 && qn > budget) budget = qn;
    @(posedge clk); @(negedge clk);
    chk({tg, " R8 used"}, int'(used_cnt), used);
    chk({tg, " R8 peak"}, int'(peak_cnt), peak);
    chk({tg, " R8 created"}, int'(created_cnt), created);
    chk({tg, " R7 budget"}, int'(budget_cur), budget);
  endtask

  task automatic look(string tg, int r);
    step(tg, 0, 0, 0, 0, 0, 0, 0, 0, r, 0, 0);
  endtask

  initial begin
    #(400000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    add_valid = 0; add_reg = 0; add_tag = 0; add_full = 0; inv_valid = 0; inv_reg = 0;
    inv_tag = 0; inv_full = 0; lk_reg = 0; q_valid = 0; q_num = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset used", int'(used_cnt), 0);
    chk("reset peak", int'(peak_cnt), 0);
    chk("reset created", int'(created_cnt), 0);
    chk("reset budget", int'(budget_cur), 8);
    chk("reset R5 mask", int'(lk_mask), 0);

    step("R1 add full reg", 1, 1, 5, 0, 0, 0, 0, 0, 1, 0, 0);
    look("R1 sub gets tag", 3);
    step("R1 add low reg", 1, 3, 2, 0, 0, 0, 0, 0, 3, 0, 0);
    look("R5 union of tags", 1);
    look("R2 partial keeps wider", 2);
    step("R2 full add spreads up", 1, 6, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    look("R2 wider overwritten", 4);
    step("R4 tag mismatch", 0, 0, 0, 0, 1, 3, 7, 0, 0, 0, 0);
    look("R4 mismatch kept", 3);
    step("R4 partial inv", 0, 0, 0, 0, 1, 5, 1, 0, 0, 0, 0);
    look("R4 wider untouched", 4);
    look("R4 narrow cleared", 5);
    step("R3 empty target", 0, 0, 0, 0, 1, 10, 0, 0, 0, 0, 0);
    step("R9 reg zero", 1, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9 reg range", 0, 0, 0, 0, 1, 13, 0, 0, 13, 0, 0);
    step("R10 add beats inv", 1, 7, 3, 0, 1, 1, 5, 0, 1, 0, 0);
    look("R10 inv dropped", 1);
    step("R6 at budget", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8 - used);
    step("R6 over budget", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 9 - used);
    step("R7 raise budget", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 12);
    step("R3 inv full reg", 0, 0, 0, 0, 1, 1, 5, 1, 2, 0, 0);
    q_num = 8'd200; #1;
    chk("R6 unlimited budget", int'(u_ok), 1);

    for (int k = 0; k < 300; k++) begin
      int op = $urandom_range(0, 9);
      step("rnd", op < 4, $urandom_range(0, 13), $urandom_range(0, 7), $urandom_range(0, 1),
           op >= 3 && op < 8, $urandom_range(0, 13), $urandom_range(0, 7), $urandom_range(0, 1),
           $urandom_range(0, 13), op == 9, $urandom_range(0, 14));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule